// File: doc/BRIEF.md
# Single-Precision Float to Unsigned Word Converter

This unit turns a 32-bit IEEE-754 single-precision operand into a 32-bit unsigned integer. The caller picks one of four rounding modes per operation. Special operands get fixed results: NaNs and any value below zero give 0, and positive values beyond the 32-bit range give all ones. The sign test is made on the raw operand before any rounding takes place. A tiny negative value such as -0.25 therefore gives 0 and raises invalid, even though rounding would have produced zero. Negative zero is treated exactly like positive zero.

Operands enter on a valid/ready stream together with their rounding mode. The result and a three-bit flag vector leave on a second valid/ready stream one cycle later, from a single output register. An input is accepted on a rising edge where `in_valid` and `in_ready` are both high, with `in_ready = !out_valid || out_ready`. A result stays valid and unchanged until it is taken on an edge with `out_ready` high. A new operand can be accepted on that same edge, so back-to-back operation runs at one conversion per cycle. A status bit, `flag_any`, reports whether the conversion now on the output raised any flag. It is loaded together with that result, so a conversion without flags clears it.

Top module: `f2u_convert`

## Requirements
- R1: Any NaN operand (exponent all ones, fraction nonzero, either sign) gives result 0 with the invalid flag set.
- R2: Any negative nonzero operand gives result 0 with invalid set and inexact clear. This includes negative denormals, negative infinity and values that would round to zero.
- R3: Positive zero and negative zero (0x80000000) give result 0 with all flags clear.
- R4: Positive infinity, and any positive value that is 2^32 or more after rounding, gives 0xFFFFFFFF with both invalid and saturate set (example: 0x56EB7395 gives 0xFFFFFFFF).
- R5: In-range positive values are rounded by `in_rmode`: 0 = nearest with ties to even, 1 = toward plus infinity, 2 = toward minus infinity, 3 = toward zero. Examples: 0x4EF32010 gives 0x79900800 and 0x4C54FD44 gives 0x0353F510 in every mode; 0x1733F6C2 and 0x2C9D9CDC give 0 except in mode 1.
- R6: Flag bits are [2] invalid, [1] saturate and [0] inexact. Inexact is set exactly when nonzero fraction bits are discarded and no invalid condition applies; it is never set together with invalid.
- R7: Positive denormals give 0 with inexact, except under mode 1 where they give 1 with inexact.
- R8: `flag_any` is high while the output holds a conversion that raised at least one flag, and low after a conversion that raised none.
- R9: `in_ready` equals `!out_valid || out_ready`. An accepted operand appears on the output after the next rising edge. The output result and flags hold steady while `out_valid` is high and `out_ready` is low.
- R10: While reset (`rst_n` low) is asserted, `out_valid` and `flag_any` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_op | input | 32 | Single-precision operand |
| in_rmode | input | 2 | Rounding mode for this operand |
| out_valid | output | 1 | Result register holds a conversion |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Unsigned integer result |
| out_flags | output | 3 | {invalid, saturate, inexact} |
| flag_any | output | 1 | Last presented conversion raised a flag |

## Verification
The bench drives small negatives such as -0.5 and the smallest negative denormal. A design that rounds before testing the sign would return 0 with only inexact set for these. Negative zero and both NaN signs are applied in all four modes, which exposes a design that treats -0 as invalid or that lets the sign test claim a NaN. The values 0.5, 0.75, 1.5 and 2.5, together with denormals, separate the four rounding modes, including ties to even. A mode-decode swap shows up as an off-by-one result. The largest float below 2^32 and 2^32 itself bracket the saturation boundary. Random back-pressure on the output checks that a stalled result does not change and that no result is dropped or duplicated.

// File: rtl/f2u_pkg.sv
package f2u_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_UP      = 2'd1,
    RM_DOWN    = 2'd2,
    RM_ZERO    = 2'd3
  } rmode_e;

  localparam int FLAG_W      = 3;
  localparam int FLG_INEXACT = 0;
  localparam int FLG_SAT     = 1;
  localparam int FLG_INVALID = 2;
endpackage

// File: rtl/f2u_classify.sv
module f2u_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int OUT_W  = 32
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output logic                  is_nan,
  output logic                  is_zero,
  output logic                  is_neg,
  output logic                  is_inf,
  output logic                  is_big,
  output logic [FRAC_W:0]       mant,
  output logic [EXP_W-1:0]      eff_exp
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] BIG_E = EXP_W'(BIAS + OUT_W);

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              ex_max, ex_min, fr_nz;

  assign sgn    = op[EXP_W+FRAC_W];
  assign ex     = op[EXP_W+FRAC_W-1:FRAC_W];
  assign fr     = op[FRAC_W-1:0];
  assign ex_max = &ex;
  assign ex_min = ~|ex;
  assign fr_nz  = |fr;

  assign is_nan  = ex_max & fr_nz;
  assign is_zero = ex_min & ~fr_nz;
  // sign is judged on the raw operand, ahead of any rounding
  assign is_neg  = sgn & ~is_zero & ~is_nan;
  assign is_inf  = ex_max & ~fr_nz;
  assign is_big  = (ex >= BIG_E);
  // denormals carry a hidden zero and the minimum exponent
  assign mant    = {~ex_min, fr};
  assign eff_exp = ex_min ? EXP_W'(1) : ex;
endmodule

// File: rtl/f2u_align_round.sv
module f2u_align_round
  import f2u_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int OUT_W  = 32
) (
  input  logic [FRAC_W:0]  mant,
  input  logic [EXP_W-1:0] eff_exp,
  input  logic [1:0]       rmode,
  output logic [OUT_W-1:0] value,
  output logic             inexact,
  output logic             carry
);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int MANT_W = FRAC_W + 1;
  localparam int GRD_W  = MANT_W + 1;
  localparam int AW     = EXP_W + 2;
  localparam logic [AW-1:0] POINT = AW'(BIAS + FRAC_W);

  logic [AW-1:0]           e_ext, lsh, rsh;
  logic [MANT_W+GRD_W-1:0] wide;
  logic [OUT_W-1:0]        trunc;
  logic                    g, st, inc;
  logic [OUT_W:0]          sum;

  always_comb begin
    e_ext = {2'b00, eff_exp};
    lsh   = '0;
    rsh   = '0;
    wide  = '0;
    trunc = '0;
    g     = 1'b0;
    st    = 1'b0;
    if (e_ext >= POINT) begin
      lsh   = e_ext - POINT;
      trunc = OUT_W'(mant) << lsh;
    end else begin
      rsh = POINT - e_ext;
      if (rsh > AW'(GRD_W)) begin
        st = |mant;
      end else begin
        wide  = {mant, {GRD_W{1'b0}}} >> rsh;
        trunc = OUT_W'(wide[MANT_W+GRD_W-1:GRD_W]);
        g     = wide[GRD_W-1];
        st    = |wide[GRD_W-2:0];
      end
    end
  end

  always_comb begin
    case (rmode_e'(rmode))
      RM_NEAREST: inc = g & (st | trunc[0]);
      RM_UP:      inc = g | st;
      default:    inc = 1'b0;
    endcase
  end

  assign sum     = {1'b0, trunc} + (OUT_W + 1)'(inc);
  assign value   = sum[OUT_W-1:0];
  assign carry   = sum[OUT_W];
  assign inexact = g | st;
endmodule

// File: rtl/f2u_convert.sv
module f2u_convert
  import f2u_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int OUT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [EXP_W+FRAC_W:0]   in_op,
  input  logic [1:0]              in_rmode,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [OUT_W-1:0]        out_result,
  output logic [FLAG_W-1:0]       out_flags,
  output logic                    flag_any
);
  logic                 is_nan, is_zero, is_neg, is_inf, is_big;
  logic [FRAC_W:0]      mant;
  logic [EXP_W-1:0]     eff_exp;
  logic [OUT_W-1:0]     rnd_val;
  logic                 rnd_inex, rnd_carry;
  logic [OUT_W-1:0]     nxt_res;
  logic [FLAG_W-1:0]    nxt_flags;
  logic                 accept;

  f2u_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_cls (
    .op(in_op), .is_nan(is_nan), .is_zero(is_zero), .is_neg(is_neg),
    .is_inf(is_inf), .is_big(is_big), .mant(mant), .eff_exp(eff_exp)
  );

  f2u_align_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_rnd (
    .mant(mant), .eff_exp(eff_exp), .rmode(in_rmode),
    .value(rnd_val), .inexact(rnd_inex), .carry(rnd_carry)
  );

  always_comb begin
    nxt_res   = '0;
    nxt_flags = '0;
    if (is_nan || is_neg) begin
      nxt_flags[FLG_INVALID] = 1'b1;
    end else if (is_zero) begin
      nxt_flags = '0;
    end else if (is_inf || is_big || rnd_carry) begin
      nxt_res                = '1;
      nxt_flags[FLG_INVALID] = 1'b1;
      nxt_flags[FLG_SAT]     = 1'b1;
    end else begin
      nxt_res                = rnd_val;
      nxt_flags[FLG_INEXACT] = rnd_inex;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
      flag_any   <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= nxt_res;
      out_flags  <= nxt_flags;
      flag_any   <= |nxt_flags;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R1
  nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (&in_op[EXP_W+FRAC_W-1:FRAC_W]) && (|in_op[FRAC_W-1:0]))
    |=> (out_valid && out_result == '0 && out_flags[FLG_INVALID]));

  // R2
  neg_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op[EXP_W+FRAC_W] && (|in_op[EXP_W+FRAC_W-1:0]))
    |=> (out_result == '0 && out_flags[FLG_INVALID] && !out_flags[FLG_INEXACT]));

  // R3
  zero_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op[EXP_W+FRAC_W-1:0] == '0)
    |=> (out_result == '0 && out_flags == '0));

  // R4
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[FLG_SAT]) |-> (out_result == '1 && out_flags[FLG_INVALID]));

  // R6
  inexact_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_flags[FLG_INEXACT] && out_flags[FLG_INVALID]));

  // R8
  clean_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op[EXP_W+FRAC_W-1:0] == '0) |=> !flag_any);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready)
    |=> (out_valid && $stable(out_result) && $stable(out_flags)));
endmodule

// File: tb/tb_f2u_convert.sv
module tb_f2u_convert;
  localparam int CLK_PERIOD = 10;
  localparam int NDIR       = 21;
  localparam int NRAND      = 3000;
  localparam int NVEC       = NDIR * 4 + NRAND;
  localparam int LIMIT      = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready, flag_any;
  logic [31:0] in_op, out_result;
  logic [1:0]  in_rmode;
  logic [2:0]  out_flags;

  always #(CLK_PERIOD / 2) clk = ~clk;

  f2u_convert dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rmode(in_rmode), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags),
    .flag_any(flag_any)
  );

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] exp_r_q[$];
  logic [2:0]  exp_f_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] dir_op(input int k);
    case (k)
      0:  return 32'h1733F6C2;
      1:  return 32'h2C9D9CDC;
      2:  return 32'h56EB7395;
      3:  return 32'h4EF32010;
      4:  return 32'h4C54FD44;
      5:  return 32'h80000000;
      6:  return 32'h00000000;
      7:  return 32'h7FC00000;
      8:  return 32'h7F800001;
      9:  return 32'hFF800000;
      10: return 32'h7F800000;
      11: return 32'hBF000000;
      12: return 32'h80000001;
      13: return 32'h00000001;
      14: return 32'h3F000000;
      15: return 32'h3FC00000;
      16: return 32'h40200000;
      17: return 32'h4F7FFFFF;
      18: return 32'h4F800000;
      19: return 32'h3F400000;
      default: return 32'hFFC00000;
    endcase
  endfunction

  // Reference: flags are {invalid, saturate, inexact}
  function automatic void model(input logic [31:0] op, input logic [1:0] rm,
                                output logic [31:0] r, output logic [2:0] fl,
                                output string tag);
    logic        s;
    int          e, ex, p, sh;
    longint      m, q, rem, half;
    bit          nz, above, tie, up;
    s = op[31];
    e = int'(op[30:23]);
    m = longint'(op[22:0]);
    if (e == 255 && m != 0) begin
      r = 0; fl = 3'b100; tag = "R1";
    end else if (e == 0 && m == 0) begin
      r = 0; fl = 3'b000; tag = "R3";
    end else if (s) begin
      r = 0; fl = 3'b100; tag = "R2";
    end else if (e == 255) begin
      r = 32'hFFFFFFFF; fl = 3'b110; tag = "R4";
    end else begin
      if (e != 0) m = m + (64'd1 << 23);
      ex = (e == 0) ? 1 : e;
      p = ex - 150;
      nz = 0; above = 0; tie = 0;
      if (p >= 0) begin
        q = (p >= 40) ? (64'd1 << 40) : (m << p);
      end else begin
        sh = -p;
        if (sh > 60) begin
          q = 0; nz = 1;
        end else begin
          q    = m >> sh;
          rem  = m - (q << sh);
          half = 64'd1 << (sh - 1);
          nz    = (rem != 0);
          above = (rem > half);
          tie   = (rem == half);
        end
      end
      case (rm)
        2'd0:    up = above || (tie && q[0]);
        2'd1:    up = nz;
        default: up = 0;
      endcase
      if (up) q = q + 1;
      if (q >= (64'd1 << 32)) begin
        r = 32'hFFFFFFFF; fl = 3'b110; tag = "R4";
      end else begin
        r = q[31:0];
        fl = nz ? 3'b001 : 3'b000;
        tag = (e == 0) ? "R7" : (nz ? "R6" : "R5");
      end
    end
  endfunction

  task automatic gen(input int i, output logic [31:0] op, output logic [1:0] rm);
    int kind;
    if (i < NDIR * 4) begin
      op = dir_op(i / 4);
      rm = 2'(i % 4);
    end else begin
      kind = int'($urandom_range(0, 3));
      rm = 2'($urandom_range(0, 3));
      case (kind)
        0: op = $urandom;
        1: op = {1'b0, 8'($urandom_range(120, 160)), 23'($urandom)};
        2: op = {1'($urandom), 8'($urandom_range(0, 2)), 23'($urandom)};
        default: op = {1'b0, 8'($urandom_range(126, 158)), 23'($urandom) & 23'h7FFF00};
      endcase
    end
  endtask

  initial begin
    int          idx, cyc;
    bit          have, stalled;
    logic [31:0] cur_op, held_r, er;
    logic [1:0]  cur_rm;
    logic [2:0]  held_f, ef;
    string       tg;
    idx = 0; cyc = 0; have = 0; stalled = 0;
    cur_op = '0; cur_rm = '0; held_r = '0; held_f = '0;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_op = '0; in_rmode = '0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R10", "out_valid in reset", 32'(out_valid), 32'd0);
    check(flag_any == 1'b0, "R10", "flag_any in reset", 32'(flag_any), 32'd0);
    check(in_ready == 1'b1, "R10", "in_ready in reset", 32'(in_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    while ((idx < NVEC || have || exp_r_q.size() > 0) && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      if (stalled) begin
        check(out_valid == 1'b1, "R9", "valid dropped while stalled", 32'(out_valid), 32'd1);
        check(out_result == held_r, "R9", "result moved while stalled", out_result, held_r);
        check(out_flags == held_f, "R9", "flags moved while stalled", 32'(out_flags), 32'(held_f));
      end
      if (!have && idx < NVEC) begin
        gen(idx, cur_op, cur_rm);
        idx++;
        have = 1;
      end
      in_valid  = have && ($urandom_range(0, 7) != 0);
      in_op     = cur_op;
      in_rmode  = cur_rm;
      out_ready = ($urandom_range(0, 3) != 0);
      #1;
      check(in_ready == (!out_valid || out_ready), "R9", "in_ready rule",
            32'(in_ready), 32'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (exp_r_q.size() == 0) begin
          check(1'b0, "R9", "result with nothing outstanding", out_result, 32'd0);
        end else begin
          er = exp_r_q.pop_front();
          ef = exp_f_q.pop_front();
          tg = tag_q.pop_front();
          check(out_result == er, tg, "result", out_result, er);
          check(out_flags == ef, (tg == "R5") ? "R6" : tg, "flags", 32'(out_flags), 32'(ef));
          check(flag_any == (|ef), "R8", "status bit", 32'(flag_any), 32'(|ef));
        end
      end
      stalled = out_valid && !out_ready;
      held_r  = out_result;
      held_f  = out_flags;
      if (in_valid && in_ready) begin
        model(cur_op, cur_rm, er, ef, tg);
        exp_r_q.push_back(er);
        exp_f_q.push_back(ef);
        tag_q.push_back(tg);
        have = 0;
      end
    end
    if (cyc >= LIMIT) begin
      vectors++;
      miscompares++;
      $display("FAIL R9 watchdog expired actual=%0d expected<%0d", cyc, LIMIT);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule